// File: doc/BRIEF.md
# SPI Byte-Streaming Memory Slave

This block is the serial front end of a byte-wide memory held in on-chip registers. A host drives chip select, serial clock and serial data in, and reads serial data out. The block oversamples all serial pins on its own system clock through two-stage synchronizers. It finds SCK edges in that sampled stream, collects one-byte commands, and runs each command against a small status register or against the array. Memory transfers stream any number of bytes from a starting address. There is no page limit and no busy period, so each written byte is stored at bus rate.

Writes are guarded in three ways. A write-enable latch must be set by its own command first. Block-protect bits fence off the upper part of the array. A write-protect pin can lock the status register. A hold pin pauses a transfer in mid-byte without losing its place. The array holds 2^ADDR_W bytes: ADDR_W = 14 gives 16 KB, and the default is a small array for fast elaboration.

Top module: `spi_nvmem_slave`

## Requirements
- R1: While cs_n is high the output enable so_oe is low and any partial command is discarded. After reset the status register reads 0x00. While selected and not held, so_oe is high.
- R2: SPI modes 0 and 3 both work. Input bits are taken on SCK rising edges, MSB first. SO changes only after an SCK falling edge and presents each output byte MSB first.
- R3: Op-code 0x06 sets the write-enable latch (status bit 1). Op-code 0x04 clears it.
- R4: Op-code 0x05 returns the status byte, repeated for as long as the host keeps clocking. The layout is bit 7 = lock enable, bits 3:2 = protect level, bit 1 = write-enable latch, and all other bits 0.
- R5: A write command (0x02) issued while the write-enable latch is clear leaves the array unchanged.
- R6: The write-enable latch clears when cs_n rises after a write (0x02) or status-write (0x01) command.
- R7: Read (0x03) and write (0x02) take two address bytes, high byte first, of which the low ADDR_W bits are used. The address advances by one per data byte and wraps from the top of the array to 0.
- R8: Any other op-code is ignored, together with all bytes that follow it, until cs_n goes high.
- R9: Op-code 0x01 followed by one byte loads the lock-enable bit from bit 7 and the protect level from bits 3:2. The update is dropped while wp_n is low and lock enable is set.
- R10: Protect level 0 protects nothing, 1 protects the top quarter of the array, 2 the top half, and 3 all of it. Writes to protected bytes are dropped, but the address still advances.
- R11: While hold_n is low, SCK edges are ignored and so_oe is low. When hold_n returns high, the transfer continues from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| wp_n | input | 1 | Write-protect pin for the status register, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the SO pad driver |

## Verification
The array is first filled with an arithmetic pattern by one streaming write that starts near the top and wraps. It is then read back across the wrap in both clock modes, with an address high byte that must be discarded. This separates correct increment and wrap from address and bit-order faults. Writes then land on either side of each protect boundary, without and after a write enable, and with the lock pin both asserted and released. These cases show which guard is actually evaluated. A hold in mid-read with toggling SCK, and an illegal op-code followed by an enable byte, show whether edges and bytes that must be ignored leave any trace.

// File: rtl/spi_nvmem_slave.sv
module spi_nvmem_slave #(
  parameter int ADDR_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {P_CMD, P_AH, P_AL, P_DATA, P_SRD, P_SWR, P_IDLE} phase_t;

  logic [4:0] s1, s2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 5'b11001;
      s2 <= 5'b11001;
    end else begin
      s1 <= {wp_n, hold_n, si, sck, cs_n};
      s2 <= s1;
    end

  wire cs_s   = s2[0];
  wire sck_s  = s2[1];
  wire si_s   = s2[2];
  wire hold_s = s2[3];
  wire wp_s   = s2[4];

  logic sck_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;

  wire active = !cs_s && hold_s;
  wire rise   = active && sck_s && !sck_q;
  wire fall   = active && !sck_s && sck_q;

  phase_t            phase;
  logic [6:0]        shreg;
  logic [2:0]        bitcnt;
  logic              rd_op;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        obyte;
  logic              so_q;
  logic              wel, wpen, wel_clr;
  logic [1:0]        bp;
  logic              prot;
  logic [7:0]        mem [DEPTH];

  wire [7:0] din    = {shreg, si_s};
  wire       bdone  = rise && (bitcnt == 3'd7);
  wire [7:0] status = {wpen, 3'b000, bp, wel, 1'b0};
  wire [1:0] top    = addr[ADDR_W-1 -: 2];
  wire       sr_lock = wpen && !wp_s;
  wire       driving = (phase == P_SRD) || (phase == P_DATA && rd_op);

  always_comb
    case (bp)
      2'd0:    prot = 1'b0;
      2'd1:    prot = &top;
      2'd2:    prot = top[1];
      default: prot = 1'b1;
    endcase

  wire mem_we = bdone && phase == P_DATA && !rd_op && wel && !prot;

  always_ff @(posedge clk)
    if (mem_we) mem[addr] <= din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase   <= P_CMD;
      shreg   <= '0;
      bitcnt  <= '0;
      rd_op   <= 1'b0;
      addr    <= '0;
      obyte   <= '0;
      so_q    <= 1'b0;
      wel     <= 1'b0;
      wel_clr <= 1'b0;
      wpen    <= 1'b0;
      bp      <= '0;
    end else if (cs_s) begin
      phase  <= P_CMD;
      bitcnt <= '0;
      if (wel_clr) begin
        wel     <= 1'b0;
        wel_clr <= 1'b0;
      end
    end else begin
      if (rise) begin
        shreg  <= din[6:0];
        bitcnt <= bitcnt + 3'd1;
      end
      if (fall && driving) so_q <= obyte[~bitcnt];
      if (bdone)
        case (phase)
          P_CMD:
            case (din)
              8'h06: begin wel <= 1'b1; phase <= P_IDLE; end
              8'h04: begin wel <= 1'b0; phase <= P_IDLE; end
              8'h05: begin obyte <= status; phase <= P_SRD; end
              8'h01: begin wel_clr <= 1'b1; phase <= P_SWR; end
              8'h03: begin rd_op <= 1'b1; phase <= P_AH; end
              8'h02: begin rd_op <= 1'b0; wel_clr <= 1'b1; phase <= P_AH; end
              default: phase <= P_IDLE;
            endcase
          P_AH: begin
            addr  <= ADDR_W'({addr, din});
            phase <= P_AL;
          end
          P_AL: begin
            if (rd_op) begin
              obyte <= mem[ADDR_W'({addr, din})];
              addr  <= ADDR_W'({addr, din}) + 1'b1;
            end else begin
              addr  <= ADDR_W'({addr, din});
            end
            phase <= P_DATA;
          end
          P_DATA: begin
            if (rd_op) obyte <= mem[addr];
            addr <= addr + 1'b1;
          end
          P_SRD: obyte <= status;
          P_SWR: begin
            if (!sr_lock) begin
              wpen <= din[7];
              bp   <= din[3:2];
            end
            phase <= P_IDLE;
          end
          default: ;
        endcase
    end

  assign so    = so_q;
  assign so_oe = active;
endmodule

// File: rtl/spi_nvmem_slave_chk.sv
module spi_nvmem_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       hold_n,
  input logic       so,
  input logic       so_oe,
  input logic       fall,
  input logic       wpen,
  input logic [1:0] bp,
  input logic       wp_s,
  input logic [7:0] status
);
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;

  p_hiz_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd3 && cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_oe);

  p_so_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && !$stable(so)) |-> $past(fall));

  p_status_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |=> $stable(status));

  p_locked_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen && !wp_s) |=> $stable({wpen, bp}));

  p_hold_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd3 && !hold_n && !$past(hold_n) && !$past(hold_n, 2)) |-> !so_oe);
endmodule

bind spi_nvmem_slave spi_nvmem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so(so), .so_oe(so_oe),
  .fall(fall), .wpen(wpen), .bp(bp), .wp_s(wp_s), .status(status)
);

// File: tb/spi_nvmem_slave_test.sv
module spi_nvmem_slave_test;
  localparam int CLK_P = 10;
  localparam int H     = 4;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, hold_n = 1, wp_n = 1;
  wire  so, so_oe;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;
  logic [7:0] model [DEPTH];
  bit   wel_e = 0, wpen_e = 0;
  logic [1:0] bp_e = 0;
  logic [7:0] r, r2;

  spi_nvmem_slave #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic sel(input bit m3);
    @(negedge clk);
    sck  = m3;
    half();
    cs_n = 0;
    half();
    if (m3) sck = 0;
  endtask

  task automatic desel(input bit m3);
    half();
    if (m3) begin sck = 1; half(); end
    cs_n = 1;
    half(); half();
    sck = 0;
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] o);
    for (int i = 7; i >= 0; i--) begin
      si = b[i];
      half();
      o[i] = so;
      sck = 1;
      half();
      sck = 0;
    end
  endtask

  function automatic bit prot_e(input int a);
    case (bp_e)
      2'd0: return 0;
      2'd1: return a >= (DEPTH * 3) / 4;
      2'd2: return a >= DEPTH / 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] stat_e();
    return {wpen_e, 3'b000, bp_e, wel_e, 1'b0};
  endfunction

  task automatic op1(input logic [7:0] op, input bit m3);
    logic [7:0] o;
    sel(m3); xfer(op, o); desel(m3);
    if (op == 8'h06) wel_e = 1;
    if (op == 8'h04) wel_e = 0;
  endtask

  task automatic rdsr_chk(input string tag);
    logic [7:0] o;
    sel(0); xfer(8'h05, o); xfer(8'h00, o); desel(0);
    check(tag, o, stat_e());
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] o;
    sel(0); xfer(8'h01, o); xfer(v, o); desel(0);
    if (!(wpen_e && !wp_n)) begin wpen_e = v[7]; bp_e = v[3:2]; end
    wel_e = 0;
  endtask

  task automatic wr_stream(input logic [15:0] a, input int n, input int seed, input bit m3);
    logic [7:0] o;
    sel(m3);
    xfer(8'h02, o); xfer(a[15:8], o); xfer(a[7:0], o);
    for (int k = 0; k < n; k++) begin
      int ad;
      logic [7:0] d;
      d  = 8'(seed + k * 13);
      ad = (a + k) % DEPTH;
      xfer(d, o);
      if (wel_e && !prot_e(ad)) model[ad] = d;
    end
    desel(m3);
    wel_e = 0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input int n, input bit m3, input string tag);
    logic [7:0] o;
    sel(m3);
    xfer(8'h03, o); xfer(a[15:8], o); xfer(a[7:0], o);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, o);
      check(tag, o, model[(a + k) % DEPTH]);
    end
    desel(m3);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 so_oe idle", so_oe, 0);
    rdsr_chk("R1 R4 reset status");

    op1(8'h06, 0);
    rdsr_chk("R3 wren sets bit1");
    wr_stream(16'h00F0, DEPTH, 3, 0);
    rdsr_chk("R6 wel cleared after write");
    rd_chk(16'h0000, DEPTH + 4, 0, "R7 stream read with wrap");
    rd_chk(16'hAB05, 10, 1, "R2 R7 mode3 read, high addr bits dropped");

    wr_stream(16'h0020, 4, 8'h11, 0);
    rd_chk(16'h0020, 4, 0, "R5 write without enable");

    op1(8'h06, 0); op1(8'h04, 0);
    rdsr_chk("R3 wrdi clears bit1");

    begin
      logic [7:0] o;
      sel(0); xfer(8'hFF, o); xfer(8'h06, o); desel(0);
    end
    rdsr_chk("R8 bad opcode ignored");

    op1(8'h06, 0);
    sel(0); xfer(8'h05, r); xfer(8'h00, r); xfer(8'h00, r2); desel(0);
    check("R4 status byte 1", r, 8'h02);
    check("R4 status byte 2", r2, 8'h02);
    op1(8'h04, 0);

    op1(8'h06, 0);
    wrsr(8'h8C);
    rdsr_chk("R9 R6 status write");
    op1(8'h06, 0);
    wr_stream(16'h0000, 3, 8'h55, 0);
    rd_chk(16'h0000, 3, 0, "R10 level3 protects all");
    rdsr_chk("R6 wel cleared after blocked write");

    wp_n = 0;
    op1(8'h06, 0);
    wrsr(8'h00);
    rdsr_chk("R9 locked status unchanged");
    wp_n = 1;
    op1(8'h06, 0);
    wrsr(8'h04);
    rdsr_chk("R9 unlock level1");

    op1(8'h06, 0);
    wr_stream(16'h00BE, 4, 8'h71, 0);
    rd_chk(16'h00BC, 8, 0, "R10 top quarter boundary");
    op1(8'h06, 0);
    wrsr(8'h08);
    op1(8'h06, 0);
    wr_stream(16'h007E, 4, 8'h92, 0);
    rd_chk(16'h007C, 8, 0, "R10 top half boundary");
    op1(8'h06, 0);
    wrsr(8'h00);
    rdsr_chk("R9 cleared level");

    op1(8'h06, 1);
    wr_stream(16'h0040, 3, 8'hC4, 1);
    rd_chk(16'h0040, 3, 0, "R2 mode3 write");

    begin
      logic [7:0] o;
      sel(0);
      xfer(8'h03, o); xfer(8'h00, o); xfer(8'h30, o);
      xfer(8'h00, o);
      check("R11 byte before hold", o, model[8'h30]);
      check("R1 so_oe while selected", so_oe, 1);
      half();
      hold_n = 0;
      repeat (4) @(negedge clk);
      check("R11 so_oe low in hold", so_oe, 0);
      for (int t = 0; t < 5; t++) begin sck = 1; half(); sck = 0; half(); end
      hold_n = 1;
      half();
      xfer(8'h00, o);
      check("R11 resume byte 1", o, model[8'h31]);
      xfer(8'h00, o);
      check("R11 resume byte 2", o, model[8'h32]);
      desel(0);
      check("R1 so_oe after deselect", so_oe, 0);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule